// File: doc/BRIEF.md
# Serial Audio Master Receiver Port

This block receives a two-channel serial audio stream and always acts as the clock master for it. It runs from a system clock at 256 times the sample rate. It divides that clock by four to make a bit clock at 64 times the sample rate, and it derives a word-select (frame) clock from the same counter. Each channel therefore takes 32 bit periods, whatever the word length.

Framing can be changed between I²S and left-justified at run time. The word length can be set from 16 to 24 bits. The block shifts in the left sample and then the right sample, MSB first. It returns each finished pair as two 24-bit words, left-aligned and zero-filled below the word length, together with a one-cycle strobe. A downstream TDM framer can then place the pair in two extra slots after the converter channels.

The divider starts on the first rising edge of the converter's frame clock after reset, so the port runs in phase with the converter frames. If the serial data input is tied low, the port delivers zero samples.

Top module: `sarx_master_rx`

## Requirements
- R1: After reset the port stays idle until it sees a rising edge of `fs_ref` (a low level followed by a high level). While idle, `bclk_o` is low, `ws_o` is at the left-channel level and `pair_valid` is low. The first rising edge of `bclk_o` comes between four and six system-clock cycles after the rising edge of `fs_ref`.
- R2: Once running, `bclk_o` is the system clock divided by four: two cycles high and two cycles low, giving 64 bit periods per frame.
- R3: `ws_o` changes only where `bclk_o` falls. It holds each level for exactly 128 system-clock cycles (32 bit periods), so a frame lasts 256 cycles.
- R4: With `fmt_i2s` = 1 (I²S framing), `ws_o` is low during the left channel, and the MSB is sampled on the second rising edge of `bclk_o` after the `ws_o` transition. With `fmt_i2s` = 0 (left-justified framing), `ws_o` is high during the left channel, and the MSB is sampled on the first rising edge after the transition.
- R5: The effective word length is `word_len` clamped to the range 16..24. Only that many bits are taken from each 32-bit channel slot, and any later bits in the slot are ignored. The sample fills bits 23 downward, and the bits below the word length read as zero.
- R6: `pair_valid` is a one-cycle pulse raised once every 256 cycles, after the right channel completes. `left_word` and `right_word` change together in that cycle and then hold their values until the next pulse.
- R7: If `sdin` is held low, both output words are zero.
- R8: During reset, `pair_valid`, `left_word`, `right_word` and `bclk_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at 256 times the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_ref | input | 1 | Converter frame clock; its first rising edge starts the divider |
| fmt_i2s | input | 1 | 1 selects I²S framing, 0 selects left-justified framing |
| word_len | input | 5 | Requested word length in bits, clamped to 16..24 |
| sdin | input | 1 | Serial audio data |
| bclk_o | output | 1 | Generated bit clock |
| ws_o | output | 1 | Generated word-select (frame) clock |
| pair_valid | output | 1 | One-cycle strobe: a new sample pair is on the outputs |
| left_word | output | 24 | Left-channel sample, left-aligned |
| right_word | output | 24 | Right-channel sample, left-aligned |

## Verification
A wrong count in the divider shows at the ports at once, within one bit period, as a bit clock or word-select edge in the wrong place. A capture offset or a length decode that is off by one does not affect the clocks. It shows only as output words moved by one bit or with a wrongly cleared tail, at the next strobe, up to 256 cycles later. For that reason every frame is compared against a sample computed from the serial slot that was driven, with random bits placed beyond the word length. A missed or doubled strobe shows as a gap between strobes that is not 256 cycles.

// File: rtl/sarx_pkg.sv
// Shared definitions for the serial audio master receiver.
// Assumes: nothing beyond IEEE 1800-2017.
package sarx_pkg;

    // Framing selector; the encoding matches the fmt_i2s port bit.
    typedef enum logic {
        SARX_FMT_LJ  = 1'b0,
        SARX_FMT_I2S = 1'b1
    } sarx_fmt_e;

    // Clamp a requested word length into [lo, hi].
    function automatic int sarx_clamp_len(input int req, input int lo, input int hi);
        if (req < lo) return lo;
        if (req > hi) return hi;
        return req;
    endfunction

endpackage

// File: rtl/sarx_fs_sync.sv
// Start detector: brings the external frame clock into the system clock
// domain and gives a single-cycle pulse on its rising edge.
// Assumes: fs_ref is asynchronous to clk and stays at each level for many cycles.
// The history resets to all-ones, so the first edge is only seen after a low level.
module sarx_fs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic fs_ref,
    output logic start
);
    logic [2:0] hist;

    // Two-flop synchroniser followed by one stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= 3'b111;
        else        hist <= {hist[1:0], fs_ref};
    end

    assign start = hist[1] & ~hist[2];
endmodule

// File: rtl/sarx_clkgen.sv
// Master clock generator: one free-running counter makes the bit clock,
// the word-select clock and the timing strobes for the capture path.
// Assumes: clk runs at (2**DIV_LOG2) * 2 * (2**SLOT_LOG2) times the sample rate.
// Counter bits: [DIV_LOG2-1:0] is the phase within a bit, the bits above it
// are the slot position, and the MSB is the channel (0 = left).
module sarx_clkgen
    import sarx_pkg::*;
#(
    parameter int DIV_LOG2  = 2,
    parameter int SLOT_LOG2 = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  sarx_fmt_e            fmt,
    output logic                 run,
    output logic                 bclk,
    output logic                 ws,
    output logic                 cap_stb,
    output logic [SLOT_LOG2-1:0] slot_pos,
    output logic                 left_end,
    output logic                 frame_end
);
    localparam int CNT_W    = DIV_LOG2 + SLOT_LOG2 + 1;
    localparam int RISE_PH  = 1 << (DIV_LOG2 - 1);
    localparam int HALF_MAX = (1 << (CNT_W - 1)) - 1;
    localparam int FULL_MAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt;

    // Running flag: set by the first frame-clock edge, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     run <= 1'b0;
        else if (start) run <= 1'b1;
    end

    // Frame counter: advances once per system clock while running.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + 1'b1;
    end

    // Clock outputs come straight from single register bits.
    assign bclk = cnt[DIV_LOG2-1];
    assign ws   = (fmt == SARX_FMT_I2S) ? cnt[CNT_W-1] : ~cnt[CNT_W-1];

    // Strobes: the first cycle with bclk high, the last cycle of the left half,
    // and the last cycle of the frame.
    assign slot_pos  = cnt[CNT_W-2:DIV_LOG2];
    assign cap_stb   = run && (int'(cnt[DIV_LOG2-1:0]) == RISE_PH);
    assign left_end  = run && (int'(cnt) == HALF_MAX);
    assign frame_end = run && (int'(cnt) == FULL_MAX);
endmodule

// File: rtl/sarx_capture.sv
// Bit capture: writes each sampled bit straight into its left-aligned
// place in a shared word register, using the slot position, the framing
// offset and the clamped word length.
// Assumes: strobes from sarx_clkgen; fmt and word_len are held steady while running.
module sarx_capture
    import sarx_pkg::*;
#(
    parameter int SLOT_LOG2 = 5,
    parameter int WORD_W    = 24,
    parameter int WL_MIN    = 16,
    parameter int WL_W      = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_stb,
    input  logic [SLOT_LOG2-1:0] slot_pos,
    input  sarx_fmt_e            fmt,
    input  logic [WL_W-1:0]      word_len,
    input  logic                 sdin,
    input  logic                 left_end,
    output logic [WORD_W-1:0]    acc,
    output logic [WORD_W-1:0]    left_hold
);
    localparam int IDX_W = $clog2(WORD_W);

    int               off;
    int               eff_len;
    int               dpos;
    logic             in_word;
    logic [IDX_W-1:0] bit_idx;

    // Position of the current slot bit inside the sample word.
    always_comb begin
        off     = (fmt == SARX_FMT_I2S) ? 1 : 0;
        eff_len = sarx_clamp_len(int'(word_len), WL_MIN, WORD_W);
        dpos    = int'(slot_pos) - off;
        in_word = (dpos >= 0) && (dpos < eff_len);
        bit_idx = IDX_W'(WORD_W - 1 - dpos);
    end

    // Word assembly: the MSB clears the tail, and each later bit sets its own place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (cap_stb && in_word) begin
            if (dpos == 0) acc <= {sdin, {(WORD_W-1){1'b0}}};
            else           acc[bit_idx] <= sdin;
        end
    end

    // Left holding register: keeps the left word while the right one is built.
    always_ff @(posedge clk) begin
        if (!rst_n)        left_hold <= '0;
        else if (left_end) left_hold <= acc;
    end
endmodule

// File: rtl/sarx_pair_reg.sv
// Output stage: copies both channel words into the output registers at
// the end of the frame and pulses the valid strobe for one cycle.
// Assumes: frame_end is a single-cycle pulse once per frame.
module sarx_pair_reg #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_end,
    input  logic [WORD_W-1:0] left_in,
    input  logic [WORD_W-1:0] right_in,
    output logic              pair_valid,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word
);
    // Valid strobe: follows frame_end by one register.
    always_ff @(posedge clk) begin
        if (!rst_n) pair_valid <= 1'b0;
        else        pair_valid <= frame_end;
    end

    // Pair registers: both words load in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_word  <= '0;
            right_word <= '0;
        end else if (frame_end) begin
            left_word  <= left_in;
            right_word <= right_in;
        end
    end
endmodule

// File: rtl/sarx_master_rx.sv
// Serial audio master receiver top: start detection, clock generation,
// bit capture and the output pair registers.
// Assumes: clk is 256 x sample rate for the default parameters; fmt_i2s and
// word_len change only while the block is held in reset.
module sarx_master_rx
    import sarx_pkg::*;
#(
    parameter int DIV_LOG2  = 2,
    parameter int SLOT_LOG2 = 5,
    parameter int WORD_W    = 24,
    parameter int WL_MIN    = 16,
    parameter int WL_W      = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_ref,
    input  logic              fmt_i2s,
    input  logic [WL_W-1:0]   word_len,
    input  logic              sdin,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              pair_valid,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word
);
    sarx_fmt_e            fmt;
    logic                 start;
    logic                 run;
    logic                 cap_stb;
    logic                 left_end;
    logic                 frame_end;
    logic [SLOT_LOG2-1:0] slot_pos;
    logic [WORD_W-1:0]    acc;
    logic [WORD_W-1:0]    left_hold;

    assign fmt = sarx_fmt_e'(fmt_i2s);

    sarx_fs_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .fs_ref (fs_ref),
        .start  (start)
    );

    sarx_clkgen #(
        .DIV_LOG2  (DIV_LOG2),
        .SLOT_LOG2 (SLOT_LOG2)
    ) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fmt       (fmt),
        .run       (run),
        .bclk      (bclk_o),
        .ws        (ws_o),
        .cap_stb   (cap_stb),
        .slot_pos  (slot_pos),
        .left_end  (left_end),
        .frame_end (frame_end)
    );

    sarx_capture #(
        .SLOT_LOG2 (SLOT_LOG2),
        .WORD_W    (WORD_W),
        .WL_MIN    (WL_MIN),
        .WL_W      (WL_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_stb   (cap_stb),
        .slot_pos  (slot_pos),
        .fmt       (fmt),
        .word_len  (word_len),
        .sdin      (sdin),
        .left_end  (left_end),
        .acc       (acc),
        .left_hold (left_hold)
    );

    sarx_pair_reg #(
        .WORD_W (WORD_W)
    ) u_pair (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .left_in    (left_hold),
        .right_in   (acc),
        .pair_valid (pair_valid),
        .left_word  (left_word),
        .right_word (right_word)
    );
endmodule

// File: rtl/sarx_master_rx_chk.sv
// Property checker for sarx_master_rx, attached to it by the bind below.
// Assumes: fmt_i2s and word_len stay steady while the block is running.
module sarx_master_rx_chk #(
    parameter int WORD_W = 24,
    parameter int WL_MIN = 16,
    parameter int WL_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              fmt_i2s,
    input logic [WL_W-1:0]   word_len,
    input logic              bclk_o,
    input logic              ws_o,
    input logic              pair_valid,
    input logic [WORD_W-1:0] left_word,
    input logic [WORD_W-1:0] right_word
);
    int                eff;
    logic [WORD_W-1:0] low_mask;

    // Bits below the clamped word length, worked out here independently.
    always_comb begin
        eff      = (int'(word_len) < WL_MIN) ? WL_MIN :
                   (int'(word_len) > WORD_W) ? WORD_W : int'(word_len);
        low_mask = ~({WORD_W{1'b1}} << (WORD_W - eff));
    end

    // R1: the clocks stay idle and no strobe appears before the start edge.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!bclk_o && !pair_valid && (ws_o == !fmt_i2s)));

    // R2: each bit-clock level lasts at least two cycles.
    assert_bclk_high_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk_o) |=> bclk_o);
    assert_bclk_low_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $fell(bclk_o)) |=> !bclk_o);

    // R3: word select moves only together with a falling bit clock.
    assert_ws_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$stable(ws_o) && $stable(fmt_i2s)) |-> ($past(bclk_o) && !bclk_o));

    // R5: the bits below the word length read as zero whenever a pair is presented.
    assert_tail_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> (((left_word & low_mask) == '0) && ((right_word & low_mask) == '0)));

    // R6: the strobe lasts a single cycle.
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R6: the words do not change between strobes.
    assert_words_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_valid && $past(rst_n)) |-> ($stable(left_word) && $stable(right_word)));
endmodule

bind sarx_master_rx sarx_master_rx_chk #(
    .WORD_W (WORD_W),
    .WL_MIN (WL_MIN),
    .WL_W   (WL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .fmt_i2s    (fmt_i2s),
    .word_len   (word_len),
    .bclk_o     (bclk_o),
    .ws_o       (ws_o),
    .pair_valid (pair_valid),
    .left_word  (left_word),
    .right_word (right_word)
);

// File: tb/sarx_master_rx_test.sv
// Bench for sarx_master_rx. It acts as the serial source, drives sdin on
// each falling bit clock from random 32-bit slots, and compares every
// presented pair with a sample computed from the slot that was driven.
module sarx_master_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs_ref = 1'b0;
    logic        cfg_i2s = 1'b1;
    logic [4:0]  cfg_len = 5'd24;
    logic        cfg_zero = 1'b0;
    logic        sdin = 1'b0;
    logic        bclk_o, ws_o, pair_valid;
    logic [23:0] left_word, right_word;

    int tests = 0;
    int fails = 0;
    int wd = 0;

    sarx_master_rx uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_ref     (fs_ref),
        .fmt_i2s    (cfg_i2s),
        .word_len   (cfg_len),
        .sdin       (sdin),
        .bclk_o     (bclk_o),
        .ws_o       (ws_o),
        .pair_valid (pair_valid),
        .left_word  (left_word),
        .right_word (right_word)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_len(input int l);
        if (l < 16) return 16;
        if (l > 24) return 24;
        return l;
    endfunction

    function automatic logic [23:0] exp_word(input logic [31:0] s, input bit i2s, input int len);
        logic [31:0] t;
        logic [23:0] m;
        t = i2s ? (s << 1) : s;
        m = 24'hFFFFFF << (24 - len);
        return t[31:8] & m;
    endfunction

    // Monitor and serial source state
    int          cyc = 0;
    logic [7:0]  fscnt = 8'd0;
    bit          prev_bclk, prev_ws, prev_fs, ws_at_fall, have_l, have_r, is_left;
    int          kpos, last_rise, last_v, last_wschg, fs_rise, first_bclk, vcount;
    logic [31:0] slot_l = '0, slot_r = '0;
    logic [23:0] hold_l, hold_r;
    string       dtag = "R4";

    always @(negedge clk) begin
        cyc++;
        fscnt  = fscnt + 8'd1;
        fs_ref = (fscnt < 8'd128);
        if (!rst_n) begin
            prev_bclk = 0; prev_ws = ws_o; prev_fs = fs_ref; ws_at_fall = ws_o;
            have_l = 0; have_r = 0; kpos = 0; last_rise = 0; last_v = 0;
            last_wschg = 0; fs_rise = 0; first_bclk = 0; vcount = 0; sdin = 0;
        end else begin
            if (fs_ref && !prev_fs && fs_rise == 0) fs_rise = cyc;
            // R2: spacing of rising bit-clock edges
            if (bclk_o && !prev_bclk) begin
                if (first_bclk == 0) first_bclk = cyc;
                else chk(cyc - last_rise == 4, "R2", "bclk rise spacing", cyc - last_rise, 4);
                last_rise = cyc;
            end
            // R4/R5/R7 data, R6 spacing and hold
            if (pair_valid) begin
                vcount++;
                if (last_v != 0) chk(cyc - last_v == 256, "R6", "valid spacing", cyc - last_v, 256);
                last_v = cyc;
                if (have_l && have_r) begin
                    chk(left_word == exp_word(slot_l, cfg_i2s, clamp_len(int'(cfg_len))), dtag,
                        "left word", left_word, exp_word(slot_l, cfg_i2s, clamp_len(int'(cfg_len))));
                    chk(right_word == exp_word(slot_r, cfg_i2s, clamp_len(int'(cfg_len))), dtag,
                        "right word", right_word, exp_word(slot_r, cfg_i2s, clamp_len(int'(cfg_len))));
                end
                hold_l = left_word; hold_r = right_word;
                have_l = 0; have_r = 0;
            end else if (last_v != 0) begin
                chk(left_word == hold_l && right_word == hold_r, "R6", "words held",
                    {left_word, right_word}, {hold_l, hold_r});
            end
            // R3: word-select timing
            if (ws_o != prev_ws && first_bclk != 0) begin
                chk(prev_bclk && !bclk_o, "R3", "ws moves on falling bclk", bclk_o, 0);
                if (last_wschg != 0) chk(cyc - last_wschg == 128, "R3", "ws half period", cyc - last_wschg, 128);
                last_wschg = cyc;
            end
            // Serial source: the next bit goes out on each falling bit clock
            if (prev_bclk && !bclk_o) begin
                is_left = (ws_o == !cfg_i2s);
                if (ws_o != ws_at_fall) begin
                    kpos = 0;
                    if (is_left) begin slot_l = cfg_zero ? 32'd0 : $urandom; have_l = 1; end
                    else         begin slot_r = cfg_zero ? 32'd0 : $urandom; have_r = 1; end
                end else if (kpos < 31) kpos++;
                ws_at_fall = ws_o;
                sdin = is_left ? slot_l[31-kpos] : slot_r[31-kpos];
            end
            prev_bclk = bclk_o; prev_ws = ws_o; prev_fs = fs_ref;
        end
    end

    task automatic run_seg(input bit i2s, input int len, input bit zero, input int frames, input string tag);
        rst_n    = 1'b0;
        cfg_i2s  = i2s;
        cfg_len  = 5'(len);
        cfg_zero = zero;
        dtag     = tag;
        repeat (4) @(negedge clk);
        // R8 reset values; R1 idle word-select level
        chk(!pair_valid && left_word == 0 && right_word == 0 && !bclk_o, "R8", "reset outputs",
            {pair_valid, bclk_o, left_word, right_word}, 0);
        chk(ws_o == !i2s, "R1", "idle ws level", ws_o, !i2s);
        rst_n = 1'b1;
        while (vcount < frames) @(negedge clk);
        // R1 start latency after the frame-clock rise
        chk(fs_rise != 0 && first_bclk - fs_rise >= 4 && first_bclk - fs_rise <= 6, "R1",
            "start latency", first_bclk - fs_rise, 5);
    endtask

    initial begin
        void'($urandom(32'h5A17));
        run_seg(1'b1, 24, 1'b0, 6, "R4");
        run_seg(1'b0, 24, 1'b0, 6, "R4");
        run_seg(1'b1, 16, 1'b0, 6, "R5");
        run_seg(1'b0, 20, 1'b0, 6, "R5");
        run_seg(1'b1, 10, 1'b0, 4, "R5");   // clamps up to 16
        run_seg(1'b0, 31, 1'b0, 4, "R5");   // clamps down to 24
        run_seg(1'b0, 18, 1'b1, 4, "R7");
        run_seg(1'b1, 24, 1'b1, 4, "R7");
        for (int i = 0; i < 4; i++)
            run_seg(1'($urandom % 2), 14 + int'($urandom % 13), 1'b0, 4, "R4");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            tests++;
            fails++;
            $display("FAIL R6 watchdog: actual %0d cycles expected fewer", wd);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule